// File: doc/BRIEF.md
# Load Data Extract and Unpack

This block sits between the memory read return path and the register file write port of a processor load pipeline. It takes an eight-byte read word, already aligned so that the addressed data starts at byte 0, and turns it into the value to be written back for the requested load flavour. The flavours are narrow loads with sign or zero extension, full word and doubleword loads, byte-to-halfword unpack loads, and shift-in loads that treat a 64-bit register pair as a small queue.

A 4-bit operation code selects the flavour. The shift-in flavours also need the current contents of the destination pair, which the block receives as a separate input. The block produces the 64-bit result together with a flag that says whether the result is for a register pair or for a single 32-bit register. Results are registered: a request presented with `in_valid` on one clock edge appears on the outputs after that edge. The outputs hold their last value when no request is presented.

Top module: `ldx_unit`

## Requirements
- R1: Opcode 0 (unsigned byte) returns rdata[7:0] zero-extended, and opcode 2 (unsigned halfword) returns rdata[15:0] zero-extended. Bits 63:32 of the result are zero.
- R2: Opcode 1 (signed byte) returns rdata[7:0] sign-extended to 32 bits, and opcode 3 (signed halfword) returns rdata[15:0] sign-extended to 32 bits. Bits 63:32 of the result are zero.
- R3: Opcode 4 (word) returns rdata[31:0] with bits 63:32 zero, and opcode 5 (doubleword) returns all 64 bits of rdata.
- R4: Opcodes 6 (zero) and 7 (sign) are the 2-lane unpack. Byte i of rdata (byte 0 = bits 7:0) is extended into halfword i of a 32-bit result, for i = 0 and 1. Bits 63:32 of the result are zero.
- R5: Opcodes 8 (zero) and 9 (sign) are the 4-lane unpack. Byte i of rdata is extended into halfword i of the 64-bit result, for i = 0 to 3.
- R6: Opcode 10 (halfword shift-in) returns (old_pair >> 16) | (rdata[15:0] << 48).
- R7: Opcode 11 (byte shift-in) returns (old_pair >> 8) | (rdata[7:0] << 56).
- R8: `wide` is 1 for opcodes 5, 8, 9, 10 and 11, and 0 for opcodes 0 to 4, 6 and 7.
- R9: Opcodes 12 to 15 are unused. A request with one of them gives out_valid = 0, result = 0 and wide = 0.
- R10: A request with in_valid = 1 updates the outputs at the next rising clock edge, and out_valid is 1 only for a legal opcode. With in_valid = 0, out_valid is 0 after the edge, and result and wide keep their previous values whatever the other inputs do.
- R11: While rst_n is low, out_valid, wide and result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Load flavour code |
| rdata | input | 64 | Aligned memory read data, byte 0 in bits 7:0 |
| old_pair | input | 64 | Current destination pair, used by the shift-in flavours |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered writeback value |
| wide | output | 1 | 1 = pair writeback, 0 = single 32-bit register |

## Verification
The bench drives bytes with the top bit set and with it clear into every signed flavour. A design that extends from the wrong bit, or ignores the sign mode, returns values that are wrong in the upper lane or upper word. The unpack vectors use four different bytes with mixed sign bits, so a swapped lane order or a lane extended with its neighbour's sign shows up at once. The shift-in flavours are run both once and as a chain of four pushes whose result is fed back. A design that shifts the wrong way, by the wrong amount, or inserts at the bottom ends with the bytes in the wrong places. Unused opcodes and idle cycles with changing inputs are also applied, which catches a design that leaks a stale or partial result or that updates while idle.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    // Datapath geometry
    localparam int LDX_BYTE_W = 8;
    localparam int LDX_HALF_W = 2 * LDX_BYTE_W;
    localparam int LDX_REG_W  = 32;
    localparam int LDX_PAIR_W = 2 * LDX_REG_W;
    localparam int LDX_OP_W   = 4;

    // Load flavour codes
    typedef enum logic [LDX_OP_W-1:0] {
        OP_UBYTE   = 4'd0,
        OP_SBYTE   = 4'd1,
        OP_UHALF   = 4'd2,
        OP_SHALF   = 4'd3,
        OP_WORD    = 4'd4,
        OP_DOUBLE  = 4'd5,
        OP_UNP2_Z  = 4'd6,
        OP_UNP2_S  = 4'd7,
        OP_UNP4_Z  = 4'd8,
        OP_UNP4_S  = 4'd9,
        OP_SHIN_H  = 4'd10,
        OP_SHIN_B  = 4'd11
    } ldx_op_e;

    localparam logic [LDX_OP_W-1:0] LDX_LAST_LEGAL = 4'd11;

    // Registered output state
    typedef struct packed {
        logic                  vld;
        logic                  wide;
        logic [LDX_PAIR_W-1:0] res;
    } ldx_state_t;

    function automatic logic ldx_is_legal(input logic [LDX_OP_W-1:0] code);
        return code <= LDX_LAST_LEGAL;
    endfunction

    function automatic logic ldx_is_signed(input logic [LDX_OP_W-1:0] code);
        return (code == OP_SBYTE) || (code == OP_SHALF) ||
               (code == OP_UNP2_S) || (code == OP_UNP4_S);
    endfunction

endpackage

// File: rtl/ldx_extend.sv
// Widen a field to a larger width, replicating its top bit when sign_en_i is set.
module ldx_extend #(
    parameter int SRC_W = 8,
    parameter int DST_W = 16
) (
    input  logic [SRC_W-1:0] src_i,
    input  logic             sign_en_i,
    output logic [DST_W-1:0] dst_o
);
    localparam int PAD_W = DST_W - SRC_W;

    logic fill;

    always_comb begin
        fill  = sign_en_i & src_i[SRC_W-1];
        dst_o = {{PAD_W{fill}}, src_i};
    end
endmodule

// File: rtl/ldx_unpack.sv
// Spread LANES bytes into LANES halfwords, lane i from byte i (little-endian).
module ldx_unpack #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic [LANES*BYTE_W-1:0] src_i,
    input  logic                    sign_en_i,
    output logic [LANES*HALF_W-1:0] dst_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ldx_extend #(
            .SRC_W(BYTE_W),
            .DST_W(HALF_W)
        ) u_ext (
            .src_i    (src_i[g*BYTE_W +: BYTE_W]),
            .sign_en_i(sign_en_i),
            .dst_o    (dst_o[g*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/ldx_shift_in.sv
// Push a chunk into the top of a register pair; old contents move down by one chunk.
module ldx_shift_in #(
    parameter int PAIR_W  = 64,
    parameter int CHUNK_W = 8
) (
    input  logic [PAIR_W-1:0]  old_i,
    input  logic [CHUNK_W-1:0] chunk_i,
    output logic [PAIR_W-1:0]  dst_o
);
    localparam int LOW_W = PAIR_W - CHUNK_W;

    logic [PAIR_W-1:0] moved;
    logic [PAIR_W-1:0] placed;

    always_comb begin
        moved  = old_i >> CHUNK_W;
        placed = {chunk_i, {LOW_W{1'b0}}};
        dst_o  = moved | placed;
    end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LDX_OP_W-1:0]   op,
    input  logic [LDX_PAIR_W-1:0] rdata,
    input  logic [LDX_PAIR_W-1:0] old_pair,
    output logic                  out_valid,
    output logic [LDX_PAIR_W-1:0] result,
    output logic                  wide
);
    localparam int UNP2_LANES = LDX_REG_W / LDX_HALF_W;
    localparam int UNP4_LANES = LDX_PAIR_W / LDX_HALF_W;
    localparam int UPPER_W    = LDX_PAIR_W - LDX_REG_W;

    ldx_state_t state_d, state_q;
    ldx_op_e    op_e;
    logic       sign_sel;

    logic [LDX_REG_W-1:0]  byte_ext;
    logic [LDX_REG_W-1:0]  half_ext;
    logic [LDX_REG_W-1:0]  unp2_res;
    logic [LDX_PAIR_W-1:0] unp4_res;
    logic [LDX_PAIR_W-1:0] shin_h_res;
    logic [LDX_PAIR_W-1:0] shin_b_res;

    always_comb begin
        op_e     = ldx_op_e'(op);
        sign_sel = ldx_is_signed(op);
    end

    // Narrow scalar extensions
    ldx_extend #(.SRC_W(LDX_BYTE_W), .DST_W(LDX_REG_W)) u_byte_ext (
        .src_i    (rdata[LDX_BYTE_W-1:0]),
        .sign_en_i(sign_sel),
        .dst_o    (byte_ext)
    );

    ldx_extend #(.SRC_W(LDX_HALF_W), .DST_W(LDX_REG_W)) u_half_ext (
        .src_i    (rdata[LDX_HALF_W-1:0]),
        .sign_en_i(sign_sel),
        .dst_o    (half_ext)
    );

    // Byte-to-halfword unpack, single register and pair forms
    ldx_unpack #(.LANES(UNP2_LANES), .BYTE_W(LDX_BYTE_W), .HALF_W(LDX_HALF_W)) u_unp2 (
        .src_i    (rdata[UNP2_LANES*LDX_BYTE_W-1:0]),
        .sign_en_i(sign_sel),
        .dst_o    (unp2_res)
    );

    ldx_unpack #(.LANES(UNP4_LANES), .BYTE_W(LDX_BYTE_W), .HALF_W(LDX_HALF_W)) u_unp4 (
        .src_i    (rdata[UNP4_LANES*LDX_BYTE_W-1:0]),
        .sign_en_i(sign_sel),
        .dst_o    (unp4_res)
    );

    // Shift-in queue loads
    ldx_shift_in #(.PAIR_W(LDX_PAIR_W), .CHUNK_W(LDX_HALF_W)) u_shin_h (
        .old_i  (old_pair),
        .chunk_i(rdata[LDX_HALF_W-1:0]),
        .dst_o  (shin_h_res)
    );

    ldx_shift_in #(.PAIR_W(LDX_PAIR_W), .CHUNK_W(LDX_BYTE_W)) u_shin_b (
        .old_i  (old_pair),
        .chunk_i(rdata[LDX_BYTE_W-1:0]),
        .dst_o  (shin_b_res)
    );

    // Next-state selection
    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (in_valid) begin
            state_d.vld  = 1'b1;
            state_d.wide = 1'b0;
            state_d.res  = '0;
            unique case (op_e)
                OP_UBYTE, OP_SBYTE: state_d.res = {{UPPER_W{1'b0}}, byte_ext};
                OP_UHALF, OP_SHALF: state_d.res = {{UPPER_W{1'b0}}, half_ext};
                OP_WORD:            state_d.res = {{UPPER_W{1'b0}}, rdata[LDX_REG_W-1:0]};
                OP_DOUBLE: begin
                    state_d.res  = rdata;
                    state_d.wide = 1'b1;
                end
                OP_UNP2_Z, OP_UNP2_S: state_d.res = {{UPPER_W{1'b0}}, unp2_res};
                OP_UNP4_Z, OP_UNP4_S: begin
                    state_d.res  = unp4_res;
                    state_d.wide = 1'b1;
                end
                OP_SHIN_H: begin
                    state_d.res  = shin_h_res;
                    state_d.wide = 1'b1;
                end
                OP_SHIN_B: begin
                    state_d.res  = shin_b_res;
                    state_d.wide = 1'b1;
                end
                default: begin
                    state_d.vld  = 1'b0;
                    state_d.wide = 1'b0;
                    state_d.res  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign wide      = state_q.wide;
    assign result    = state_q.res;

    // Unused codes leave nothing behind
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ldx_is_legal(op)) |=> (!out_valid && !wide && result == '0));

    // Legal request produces a valid result one edge later
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ldx_is_legal(op)) |=> out_valid);

    // Idle cycles keep the outputs
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(wide)));

    // Single-register writebacks (R1, R2, R4) never carry upper bits
    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide) |-> (result[LDX_PAIR_W-1:LDX_REG_W] == '0));

    // Doubleword is a pair writeback
    assert_double_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_DOUBLE) |=> (wide && result == $past(rdata)));

    // Byte shift-in: old pair moves down one byte
    assert_shin_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHIN_B) |=>
            (result[LDX_PAIR_W-LDX_BYTE_W-1:0] == $past(old_pair[LDX_PAIR_W-1:LDX_BYTE_W])));

    // Halfword shift-in: new halfword lands on top
    assert_shin_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHIN_H) |=>
            (result[LDX_PAIR_W-1:LDX_PAIR_W-LDX_HALF_W] == $past(rdata[LDX_HALF_W-1:0])));
endmodule

// File: tb/ldx_unit_test.sv
`timescale 1ns/1ps
module ldx_unit_test;

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] rd;
        logic [63:0] old;
        logic [63:0] exp;
        logic        wide;
        logic        vld;
    } vec_t;

    localparam logic [63:0] DA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] DB = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] DC = 64'h0000_0000_7F80_01FF;
    localparam logic [63:0] OP = 64'h1111_2222_3333_4444;
    localparam int NVEC = 18;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  DA, 64'd0, 64'h0000_0000_0000_00EF, 1'b0, 1'b1},
        '{4'd1,  DA, 64'd0, 64'h0000_0000_FFFF_FFEF, 1'b0, 1'b1},
        '{4'd1,  DB, 64'd0, 64'h0000_0000_0000_0010, 1'b0, 1'b1},
        '{4'd2,  DA, 64'd0, 64'h0000_0000_0000_CDEF, 1'b0, 1'b1},
        '{4'd3,  DA, 64'd0, 64'h0000_0000_FFFF_CDEF, 1'b0, 1'b1},
        '{4'd3,  DB, 64'd0, 64'h0000_0000_0000_3210, 1'b0, 1'b1},
        '{4'd4,  DA, 64'd0, 64'h0000_0000_89AB_CDEF, 1'b0, 1'b1},
        '{4'd5,  DA, 64'd0, DA,                      1'b1, 1'b1},
        '{4'd6,  DA, 64'd0, 64'h0000_0000_00CD_00EF, 1'b0, 1'b1},
        '{4'd7,  DA, 64'd0, 64'h0000_0000_FFCD_FFEF, 1'b0, 1'b1},
        '{4'd7,  DB, 64'd0, 64'h0000_0000_0032_0010, 1'b0, 1'b1},
        '{4'd8,  DA, 64'd0, 64'h0089_00AB_00CD_00EF, 1'b1, 1'b1},
        '{4'd9,  DA, 64'd0, 64'hFF89_FFAB_FFCD_FFEF, 1'b1, 1'b1},
        '{4'd9,  DC, 64'd0, 64'h007F_FF80_0001_FFFF, 1'b1, 1'b1},
        '{4'd10, DA, OP,    64'hCDEF_1111_2222_3333, 1'b1, 1'b1},
        '{4'd11, DA, OP,    64'hEF11_1122_2233_3344, 1'b1, 1'b1},
        '{4'd12, DA, OP,    64'd0,                   1'b0, 1'b0},
        '{4'd15, DB, OP,    64'd0,                   1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [63:0] rdata = '0;
    logic [63:0] old_pair = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        wide;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ldx_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op),
        .rdata    (rdata),
        .old_pair (old_pair),
        .out_valid(out_valid),
        .result   (result),
        .wide     (wide)
    );

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0, 4'd2:         return "R1";
            4'd1, 4'd3:         return "R2";
            4'd4, 4'd5:         return "R3";
            4'd6, 4'd7:         return "R4";
            4'd8, 4'd9:         return "R5";
            4'd10:              return "R6";
            4'd11:              return "R7";
            default:            return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got vld=%b wide=%b res=%h, expected vld=%b wide=%b res=%h",
                     tag, act[65], act[64], act[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] c,
                         input logic [63:0] d, input logic [63:0] o);
        @(negedge clk);
        in_valid = v;
        op       = c;
        rdata    = d;
        old_pair = o;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] chain;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 reset", {out_valid, wide, result}, 66'd0);
        rst_n = 1'b1;

        // Vector table: R1..R9 and per-vector R8 wide flag, R10 valid timing
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].rd, VECS[i].old);
            check($sformatf("%s/R8/R10 vector %0d", req_of(VECS[i].op), i),
                  {out_valid, wide, result},
                  {VECS[i].vld, VECS[i].wide, VECS[i].exp});
        end

        // R10: idle cycle with changing inputs holds result and wide
        drive(1'b1, 4'd4, DA, 64'd0);
        drive(1'b0, 4'd5, DB, OP);
        check("R10 idle hold", {out_valid, wide, result},
              {1'b0, 1'b0, 64'h0000_0000_89AB_CDEF});
        drive(1'b0, 4'd11, DC, DB);
        check("R10 idle hold again", {out_valid, wide, result},
              {1'b0, 1'b0, 64'h0000_0000_89AB_CDEF});

        // R7: chain of byte pushes fed back as the old pair
        chain = '0;
        for (int k = 1; k <= 4; k++) begin
            drive(1'b1, 4'd11, {56'hA5A5_A5A5_A5A5_A5, 8'(k * 8'h11)}, chain);
            chain = result;
        end
        check("R7 byte push chain", {out_valid, wide, result},
              {1'b1, 1'b1, 64'h4433_2211_0000_0000});

        // R6: two halfword pushes chained
        drive(1'b1, 4'd10, 64'hFFFF_FFFF_FFFF_BEEF, 64'h0000_0000_0000_0000);
        chain = result;
        drive(1'b1, 4'd10, 64'h0000_0000_0000_CAFE, chain);
        check("R6 half push chain", {out_valid, wide, result},
              {1'b1, 1'b1, 64'hCAFE_BEEF_0000_0000});

        // R9 after a wide result: unused code clears everything
        drive(1'b1, 4'd13, DA, OP);
        check("R9 after wide", {out_valid, wide, result}, 66'd0);

        // R11: reset asserted mid-run clears outputs
        drive(1'b1, 4'd5, DB, 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset", {out_valid, wide, result}, 66'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule